// File: doc/BRIEF.md
# Serial Peripheral Master Shift Engine

This block is the bit-level core of a serial peripheral master. It takes whole words from a transmit word source into an internal shift register and clocks them onto a serial data output against a generated serial clock. It samples the serial data input at the configured edge and hands each complete received word to a receive word sink. The source and sink are normally FIFOs, and those FIFOs sit outside the block. The serial clock comes from the module clock through a 16-bit reload divider. One SCLK period lasts `2*(cfg_div+1)` module clocks.

A frame configuration sets the word length, clock polarity, sampling phase, line idle level, bit order, internal loopback and the independent transmit and receive suppressions. The block takes this configuration only while it is disabled and has no word in flight. While it is enabled, the block pulls a new word whenever the shift register is free. Words follow each other with no gap as long as the source keeps offering them. When the source runs dry at a word boundary, clocking stops and SCLK returns to its idle level. `busy` covers the whole time a word sits in the shift register, including its final clock edge.

Top module: `spim_engine`

## Requirements
- R1: A serial clock half-period lasts `cfg_div+1` module clocks, so one SCLK period is `2*(cfg_div+1)` module clocks; `cfg_div` is 16 bits wide and 0 gives half the module clock.
- R2: `cfg_len` (5 bits) holds the number of bits per word minus one. Every length from 2 to 32 bits, including 2 to 8, 16 and 32, shifts exactly `cfg_len+1` bits per word.
- R3: Received words appear on `rx_data` right-justified to `cfg_len+1` bits, with all higher bits zero.
- R4: `sclk` rests at `cfg_pol` when no word is shifting. With `cfg_pha`=1 the first bit is on `mosi` before the first edge and data is sampled on the leading edge (away from `cfg_pol`). With `cfg_pha`=0 data changes on the leading edge and is sampled on the trailing edge.
- R5: While no word is shifting, `mosi` sits at `cfg_idle`.
- R6: With `cfg_msb`=1 bit `cfg_len` of a word goes first on the wire. With `cfg_msb`=0 bit 0 goes first. Received bits are placed with the same ordering.
- R7: With `cfg_loop`=1 the receiver samples the block's own `mosi` value and ignores `miso`.
- R8: With `cfg_txoff`=1 words are still pulled and clocked, but `mosi` stays at `cfg_idle` throughout.
- R9: With `cfg_rxoff`=1 no received word is pushed: `rx_valid` stays low.
- R10: `busy` rises when a word is taken and stays high until the last bit's final edge of the last queued word, with no drop between back-to-back words. `rx_valid` pulses for one cycle after each word ends.
- R11: When no word is offered at a word boundary, the engine stops: `busy` falls, `sclk` returns to `cfg_pol`, and `tx_ready` stays high while enabled.
- R12: Configuration inputs are captured only while `enable`=0 and `busy`=0. Changes made while enabled have no effect. `tx_ready` is never high while `enable`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 = operational, 0 = configuration mode |
| cfg_div | input | 16 | Serial clock reload value |
| cfg_len | input | 5 | Bits per word minus one |
| cfg_pol | input | 1 | SCLK idle level |
| cfg_pha | input | 1 | 1 = sample on leading edge, 0 = sample on trailing edge |
| cfg_idle | input | 1 | MOSI level while not shifting |
| cfg_msb | input | 1 | 1 = most significant bit first |
| cfg_loop | input | 1 | Internal loopback of MOSI to the receiver |
| cfg_txoff | input | 1 | Hold MOSI at idle level during words |
| cfg_rxoff | input | 1 | Suppress received word pushes |
| tx_data | input | 32 | Word offered for transmission |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Engine takes the offered word this cycle |
| rx_data | output | 32 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle push of `rx_data` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is in the shift register |

## Verification
The hardest case to reach from the ports is the word boundary where the last bit's sampling edge and the load of the next word fall in the same module clock. This happens with the trailing-edge sampling phase at divider 0, and it is the one place where a wrong order of sample capture and reload would corrupt data. The bench reaches it by keeping `tx_valid` asserted with the next word as soon as the previous one is accepted, at `cfg_div`=0 in both phases. An external slave model changes `miso` only after each sampling edge it sees, so every wire bit and every received bit can be compared. A second hard case is a configuration change made while enabled. The bench changes the length and bit order after `enable` rises and checks that the word still follows the frozen settings.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned SPIM_DW   = 32;
    localparam int unsigned SPIM_DIVW = 16;
    localparam int unsigned SPIM_LENW = $clog2(SPIM_DW);

    // Frame settings frozen while a word is in flight
    typedef struct packed {
        logic [SPIM_LENW-1:0] len;       // bits per word minus one
        logic                 pol;       // sclk rest level
        logic                 lead_smp;  // 1: sample on leading edge
        logic                 idle;      // mosi rest level
        logic                 msb;       // msb first
        logic                 loop;      // internal loopback
        logic                 txoff;     // hold mosi at rest level
        logic                 rxoff;     // no receive pushes
    } spim_mode_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } spim_st_t;

    // Position inside the word of the idx-th bit on the wire
    function automatic logic [SPIM_LENW-1:0] wire_pos(
        input logic [SPIM_LENW-1:0] len,
        input logic                 msb,
        input logic [SPIM_LENW-1:0] idx
    );
        return msb ? (len - idx) : idx;
    endfunction

endpackage

// File: rtl/spim_cfg_hold.sv
module spim_cfg_hold
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W = SPIM_DIVW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             busy,
    input  spim_mode_t       mode_in,
    input  logic [DIV_W-1:0] div_in,
    output spim_mode_t       mode_q,
    output logic [DIV_W-1:0] div_q
);

    localparam spim_mode_t MODE_RST = '{
        len:      SPIM_LENW'(7),
        pol:      1'b0,
        lead_smp: 1'b1,
        idle:     1'b0,
        msb:      1'b1,
        loop:     1'b0,
        txoff:    1'b1,
        rxoff:    1'b1
    };

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RST;
            div_q  <= '0;
        end else if (!enable && !busy) begin
            mode_q <= mode_in;
            div_q  <= div_in;
        end
    end

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W = SPIM_DIVW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W = SPIM_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  spim_mode_t        mode,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              miso,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);

    localparam int unsigned LEN_W = SPIM_LENW;

    spim_st_t          st_q;
    logic              half_q;    // 0: before leading edge, 1: before trailing edge
    logic              act_q;     // sclk away from its rest level
    logic              mosi_q;
    logic [LEN_W-1:0]  idx_q;
    logic [DATA_W-1:0] txw_q;
    logic [DATA_W-1:0] rxw_q;

    logic              last_bit;
    logic              word_end;
    logic              take;
    logic              smp_now;
    logic              smp_bit;
    logic [LEN_W-1:0]  drv_idx;
    logic              drv_bit;
    logic              first_bit;
    logic [DATA_W-1:0] rx_nxt;

    assign busy     = (st_q == ST_SHIFT);
    assign last_bit = (idx_q == mode.len);
    assign word_end = busy && tick && half_q && last_bit;
    assign tx_ready = enable && (!busy || word_end);
    assign take     = tx_ready && tx_valid;

    assign sclk = mode.pol ^ act_q;
    assign mosi = busy ? mosi_q : mode.idle;

    assign smp_bit = mode.loop ? mosi : miso;
    assign smp_now = busy && tick && (half_q != mode.lead_smp);

    assign drv_idx   = mode.lead_smp ? (idx_q + LEN_W'(1)) : idx_q;
    assign drv_bit   = mode.txoff ? mode.idle
                                  : txw_q[wire_pos(mode.len, mode.msb, drv_idx)];
    assign first_bit = mode.txoff ? mode.idle
                                  : tx_data[wire_pos(mode.len, mode.msb, '0)];

    always_comb begin
        rx_nxt = rxw_q;
        if (smp_now) begin
            rx_nxt[wire_pos(mode.len, mode.msb, idx_q)] = smp_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            half_q   <= 1'b0;
            act_q    <= 1'b0;
            mosi_q   <= 1'b0;
            idx_q    <= '0;
            txw_q    <= '0;
            rxw_q    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rxw_q    <= rx_nxt;
            if (busy && tick) begin
                if (!half_q) begin
                    act_q  <= 1'b1;
                    half_q <= 1'b1;
                    if (!mode.lead_smp) begin
                        mosi_q <= drv_bit;
                    end
                end else begin
                    act_q  <= 1'b0;
                    half_q <= 1'b0;
                    if (last_bit) begin
                        rx_data  <= rx_nxt;
                        rx_valid <= !mode.rxoff;
                        st_q     <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (mode.lead_smp) begin
                            mosi_q <= drv_bit;
                        end
                    end
                end
            end
            if (take) begin
                st_q   <= ST_SHIFT;
                half_q <= 1'b0;
                act_q  <= 1'b0;
                idx_q  <= '0;
                txw_q  <= tx_data;
                rxw_q  <= '0;
                mosi_q <= mode.lead_smp ? first_bit : mode.idle;
            end
        end
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W = SPIM_DW,
    parameter int unsigned DIV_W  = SPIM_DIVW,
    parameter int unsigned LEN_W  = SPIM_LENW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_pol,
    input  logic              cfg_pha,
    input  logic              cfg_idle,
    input  logic              cfg_msb,
    input  logic              cfg_loop,
    input  logic              cfg_txoff,
    input  logic              cfg_rxoff,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);

    spim_mode_t       mode_in;
    spim_mode_t       mode_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;

    always_comb begin
        mode_in.len      = cfg_len;
        mode_in.pol      = cfg_pol;
        mode_in.lead_smp = cfg_pha;
        mode_in.idle     = cfg_idle;
        mode_in.msb      = cfg_msb;
        mode_in.loop     = cfg_loop;
        mode_in.txoff    = cfg_txoff;
        mode_in.rxoff    = cfg_rxoff;
    end

    spim_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .busy    (busy),
        .mode_in (mode_in),
        .div_in  (cfg_div),
        .mode_q  (mode_q),
        .div_q   (div_q)
    );

    spim_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (div_q),
        .tick (tick)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .mode     (mode_q),
        .tick     (tick),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .miso     (miso),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .sclk     (sclk),
        .mosi     (mosi),
        .busy     (busy)
    );

endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W = SPIM_DW,
    parameter int unsigned DIV_W  = SPIM_DIVW
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              busy,
    input logic              sclk,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input spim_mode_t        mode,
    input logic [DIV_W-1:0]  div
);

    // R12: no word is accepted in configuration mode
    a_r12_ready_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> enable);

    // R12: frame settings do not move while a word is in flight
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(mode) && $stable(div)));

    // R10: an accepted word makes the engine busy
    a_r10_busy_on_take: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> busy);

    // R11: an idle enabled engine offers to take a word
    a_r11_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && enable) |-> tx_ready);

    // R4: serial clock does not move while nothing shifts and settings hold
    a_r4_sclk_still: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(mode)) |-> $stable(sclk));

    // R3: bits above the word length are zero in every pushed word
    a_r3_rx_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ((rx_data >> ({1'b0, mode.len} + 6'd1)) == '0));

    // R9: receive suppression blocks every push
    a_r9_rxoff_silent: assert property (@(posedge clk) disable iff (rst)
        mode.rxoff |-> !rx_valid);

endmodule

bind spim_engine spim_engine_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .busy     (busy),
    .sclk     (sclk),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .mode     (mode_q),
    .div      (div_q)
);

// File: tb/spim_engine_test.sv
module spim_engine_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [4:0]  cfg_len = 5'd7;
    logic        cfg_pol = 1'b0, cfg_pha = 1'b1, cfg_idle = 1'b0, cfg_msb = 1'b1;
    logic        cfg_loop = 1'b0, cfg_txoff = 1'b0, cfg_rxoff = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        miso = 1'b0;
    logic        tx_ready, rx_valid, sclk, mosi, busy;
    logic [31:0] rx_data;

    always #(PERIOD/2) clk = ~clk;

    spim_engine uut (
        .clk(clk), .rst(rst), .enable(enable), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_pol(cfg_pol), .cfg_pha(cfg_pha), .cfg_idle(cfg_idle), .cfg_msb(cfg_msb),
        .cfg_loop(cfg_loop), .cfg_txoff(cfg_txoff), .cfg_rxoff(cfg_rxoff),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
        .miso(miso), .busy(busy)
    );

    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [127:0] sp;           // slave bits in wire order
    logic [255:0] capv;         // mosi bits seen at sampling edges
    logic [31:0] txq [0:7];
    logic [31:0] rxq [0:7];
    int          kc = 0, rn = 0, cyc = 0, last_lead = 0, lead_per = 0;
    int          drops = 0;
    bit          in_burst = 0;
    logic        cur_pol = 0, cur_lead = 1;
    logic        sclk_prev = 0, mosi_prev = 0;

    // slave model and observers
    always @(negedge clk) begin
        cyc++;
        if (sclk !== sclk_prev) begin
            if (sclk != cur_pol) begin
                lead_per  = cyc - last_lead;
                last_lead = cyc;
            end
            if ((sclk != cur_pol) == cur_lead) begin
                if (kc < 256) capv[kc] = mosi_prev;
                kc++;
            end
        end
        miso = sp[kc % 128];
        if (rx_valid) begin
            if (rn < 8) rxq[rn] = rx_data;
            rn++;
        end
        if (in_burst && !busy) drops++;
        sclk_prev = sclk;
        mosi_prev = mosi;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic configure(input int div, input int len, input bit pol, input bit pha,
                             input bit idle, input bit msb, input bit lp, input bit txo,
                             input bit rxo, input logic [127:0] pat);
        enable   = 0;
        cfg_div  = 16'(div);
        cfg_len  = 5'(len);
        cfg_pol  = pol;  cfg_pha  = pha;  cfg_idle = idle; cfg_msb = msb;
        cfg_loop = lp;   cfg_txoff = txo; cfg_rxoff = rxo;
        cur_pol  = pol;  cur_lead = pha;
        sp       = pat;
        repeat (3) @(negedge clk);
        kc = 0; rn = 0; drops = 0; capv = '0;
        @(negedge clk);
        enable = 1;
        @(negedge clk);
    endtask

    task automatic run_words(input int n);
        for (int i = 0; i < n; i++) begin
            tx_data  = txq[i];
            tx_valid = 1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            in_burst = 1;
        end
        tx_valid = 0;
        in_burst = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input string tag, input int n, input int len, input bit msb,
                          input bit lp, input bit txo, input bit idle);
        int L;
        logic [31:0] capw, txe, rxe;
        L = len + 1;
        check({tag, " bit count"}, 32'(kc), 32'(n * L));
        check({tag, " push count"}, 32'(rn), 32'(n));
        for (int j = 0; j < n; j++) begin
            capw = '0; txe = '0; rxe = '0;
            for (int i = 0; i < L; i++) begin
                int p;
                p = msb ? (len - i) : i;
                capw[p] = capv[j*L + i];
                txe[p]  = txo ? idle : txq[j][p];
                rxe[p]  = lp ? txe[p] : sp[(j*L + i) % 128];
            end
            check({tag, " wire word"}, capw, txe);
            check({tag, " rx word"}, rxq[j], rxe);
        end
    endtask

    task automatic t_reset();
        check("R11 reset sclk", 32'(sclk), 0);
        check("R5 reset mosi", 32'(mosi), 0);
        check("R10 reset busy", 32'(busy), 0);
        check("R10 reset rx_valid", 32'(rx_valid), 0);
        check("R12 reset tx_ready", 32'(tx_ready), 0);
    endtask

    task automatic t_mode0_msb8();
        configure(1, 7, 0, 1, 0, 1, 0, 0, 0, 128'h3C5A_9F01_7E42_C3A5_0F1E_2D3C_4B5A_6978);
        txq[0] = 32'hFFFF_FFA5; txq[1] = 32'h0000_003C;
        run_words(2);
        verify("R2/R4/R6 mode0 msb 8b", 2, 7, 1, 0, 0, 0);
        check("R10 busy no drop", 32'(drops), 0);
        check("R11 sclk rest", 32'(sclk), 0);
        check("R5 mosi rest", 32'(mosi), 0);
    endtask

    task automatic t_mode3_lsb16();
        configure(0, 15, 1, 0, 1, 0, 0, 0, 0, 128'hA5C3_1234_F00F_8421_6789_ABCD_0FF0_5AA5);
        txq[0] = 32'h0000_B00F; txq[1] = 32'h0000_1E2D; txq[2] = 32'h0000_8001;
        run_words(3);
        verify("R4/R6 mode3 lsb 16b", 3, 15, 0, 0, 0, 1);
        check("R10 back-to-back busy", 32'(drops), 0);
        check("R11 sclk rest high", 32'(sclk), 1);
        check("R5 mosi rest high", 32'(mosi), 1);
    endtask

    task automatic t_loop32();
        configure(0, 31, 0, 0, 0, 1, 1, 0, 0, ~128'h0);
        txq[0] = 32'h1234_5678; txq[1] = 32'h8000_0001;
        run_words(2);
        verify("R7 loopback 32b", 2, 31, 1, 1, 0, 0);
    endtask

    task automatic t_len2();
        configure(2, 1, 1, 1, 0, 1, 0, 0, 0, ~128'h0);
        txq[0] = 32'hFFFF_FFFE;
        run_words(1);
        verify("R2 2b", 1, 1, 1, 0, 0, 0);
        check("R3 right justified", rxq[0], 32'h3);
    endtask

    task automatic t_txoff();
        configure(1, 4, 0, 1, 1, 1, 1, 1, 0, '0);
        txq[0] = 32'h0000_0000; txq[1] = 32'h0000_0005;
        run_words(2);
        verify("R8 txoff 5b", 2, 4, 1, 1, 1, 1);
        check("R8 rx all idle", rxq[0], 32'h1F);
    endtask

    task automatic t_rxoff();
        configure(0, 7, 0, 1, 0, 1, 0, 0, 1, ~128'h0);
        txq[0] = 32'h55;
        run_words(1);
        check("R9 rxoff no push", 32'(rn), 0);
        check("R9 rxoff still clocks", 32'(kc), 8);
    endtask

    task automatic t_divider();
        configure(4, 7, 0, 1, 0, 1, 0, 0, 0, '0);
        txq[0] = 32'h81;
        run_words(1);
        check("R1 sclk period div4", 32'(lead_per), 10);
        configure(0, 7, 0, 1, 0, 1, 0, 0, 0, '0);
        run_words(1);
        check("R1 sclk period div0", 32'(lead_per), 2);
    endtask

    task automatic t_cfg_frozen();
        configure(1, 7, 0, 1, 0, 1, 0, 0, 0, 128'h96);
        cfg_len = 5'd3; cfg_msb = 0; cfg_div = 16'd9;
        txq[0] = 32'hC6;
        run_words(1);
        verify("R12 change while enabled", 1, 7, 1, 0, 0, 0);
        check("R12 divider frozen", 32'(lead_per), 4);
    endtask

    task automatic t_disabled();
        int seen;
        configure(0, 7, 0, 1, 0, 1, 0, 0, 0, '0);
        enable = 0;
        tx_data = 32'hAA; tx_valid = 1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_ready || busy) seen++;
        end
        tx_valid = 0;
        check("R12 no take while disabled", 32'(seen), 0);
        check("R11 sclk rest disabled", 32'(sclk), 0);
        check("R12 no bits disabled", 32'(kc), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_mode0_msb8();
        t_mode3_lsb16();
        t_loop32();
        t_len2();
        t_txoff();
        t_rxoff();
        t_divider();
        t_cfg_frozen();
        t_disabled();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule